// File: doc/BRIEF.md
# Latched Edge Interrupt Controller

This block merges three event sources into a single level-sensitive interrupt request for a host. The sources are a digital I/O line (bit 3 of the third I/O port), an external input pin and a periodic tick taken from a counter output. Each source is brought into the clock domain through a two-stage synchronizer. Its rising edge is detected on the synchronized level, and a qualifying edge sets one sticky pending latch. Board straps choose whether the digital line or the external pin feeds the shared digital/external group, and they enable that group and the tick source separately.

Software controls the block with address-only writes on a small host bus, made of a write strobe and a 4-bit offset. A write to offset 0xE arms the controller, 0xD disarms it and 0xF clears the pending latch. No data travels with these commands. An active-low inhibit pin, synchronized like the sources, gates the request and blocks capture while it is low. The request output is high only when the latch is set, the controller is armed and the inhibit pin is high.

Internally, one four-state machine holds the pair (armed, pending). The states are `ST_OFF_IDLE` (disarmed, nothing pending; the reset state), `ST_OFF_HELD` (disarmed, pending), `ST_ON_IDLE` (armed, nothing pending) and `ST_ON_HELD` (armed, pending; the request is shown). The transitions are named as follows:
- arm: OFF_IDLE to ON_IDLE, and OFF_HELD to ON_HELD.
- disarm: ON_IDLE to OFF_IDLE, ON_HELD to OFF_HELD, and ON_IDLE to OFF_HELD if an edge is captured in the same cycle.
- capture: ON_IDLE to ON_HELD.
- clear: ON_HELD to ON_IDLE, and OFF_HELD to OFF_IDLE.
- clear-lost: ON_HELD stays in ON_HELD when a capture coincides with a clear.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the request output is 0, the controller is disarmed and the pending latch is empty.
- R2: A write strobe with offset 0xE arms the controller. The command is decoded from the address alone.
- R3: With the source-select strap at 0 and the group strap at 1, a rising edge on the digital line sets the pending latch while the controller is armed. A falling edge sets nothing, and the latch stays set after the line returns low.
- R4: With the source-select strap at 1, the external pin feeds the group and edges on the digital line are ignored.
- R5: With the group strap at 0, edges on neither the digital line nor the external pin set the latch.
- R6: A rising edge of the tick input sets the latch only when the tick strap is 1.
- R7: A write with offset 0xD disarms the controller and drops the request. Edges that arrive while disarmed are not captured, and a latch set before the disarm is retained.
- R8: A write with offset 0xF clears the pending latch. If a qualifying edge reaches the latch in the same cycle as the clear, the edge wins and the latch stays set.
- R9: While the synchronized inhibit pin is low, the request is 0 and edges are not captured. When the pin returns high, a latch that was already pending shows again.
- R10: The request equals pending AND armed AND inhibit-high, so re-arming with a pending latch raises the request.
- R11: Writes to any offset other than 0xD, 0xE and 0xF change neither the armed state nor the latch.
- R12: The request rises on the third rising clock edge after a qualifying source input goes high: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per command |
| bus_addr | input | 4 | Host write offset |
| dio_in | input | 1 | Digital I/O line (port bit 3), asynchronous |
| ext_in | input | 1 | External interrupt pin, asynchronous |
| tick_in | input | 1 | Counter output used as periodic tick, asynchronous |
| inhibit_n | input | 1 | Active-low interrupt inhibit pin, asynchronous |
| strap_src_sel | input | 1 | Group source: 0 digital line, 1 external pin |
| strap_grp_en | input | 1 | Enables the digital/external group |
| strap_tick_en | input | 1 | Enables the tick source |
| irq_out | output | 1 | Host interrupt request, active high |

## Verification
Two functions can land on the same clock edge: a software clear and a freshly detected edge on an armed source. The bench sets the latch first and lets the source fall. It then raises the source again and places the clear strobe so that it is sampled on the same edge as the detected rise, two cycles after the input change. The request must still be high afterwards, because the edge wins. A lone clear then drops it. The arm and disarm commands are also issued while edges arrive, and their results are judged at the request pin.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Positions of the asynchronous inputs in the synchronizer vector
    localparam int SRC_DIO  = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_TICK = 2;
    localparam int SRC_N    = 3;
    localparam int SYNC_W   = SRC_N + 1;   // sources plus the inhibit pin

    // Armed bit is the MSB, pending bit the LSB
    typedef enum logic [1:0] {
        ST_OFF_IDLE = 2'b00,
        ST_OFF_HELD = 2'b01,
        ST_ON_IDLE  = 2'b10,
        ST_ON_HELD  = 2'b11
    } irq_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= d;
    end

    assign rise = d & ~prev;

endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_arm,
    input  logic cmd_disarm,
    input  logic cmd_clear,
    input  logic edge_hit,
    input  logic inh_ok,
    output logic armed,
    output logic pending,
    output logic irq_req
);

    irq_state_t state, state_nx;
    logic       capture;

    // A detected edge only counts while the inhibit pin is released
    assign capture = edge_hit & inh_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF_IDLE: begin
                if (cmd_arm) state_nx = ST_ON_IDLE;                // arm
            end
            ST_OFF_HELD: begin
                if (cmd_arm)        state_nx = ST_ON_HELD;         // arm
                else if (cmd_clear) state_nx = ST_OFF_IDLE;        // clear
            end
            ST_ON_IDLE: begin
                if (cmd_disarm)   state_nx = capture ? ST_OFF_HELD : ST_OFF_IDLE; // disarm
                else if (capture) state_nx = ST_ON_HELD;           // capture
            end
            ST_ON_HELD: begin
                if (cmd_disarm)     state_nx = ST_OFF_HELD;        // disarm
                else if (cmd_clear) state_nx = capture ? ST_ON_HELD : ST_ON_IDLE; // clear / clear-lost
            end
            default: state_nx = ST_OFF_IDLE;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        pending = 1'b0;
        irq_req = 1'b0;
        unique case (state)
            ST_OFF_IDLE: ;
            ST_OFF_HELD: pending = 1'b1;
            ST_ON_IDLE:  armed   = 1'b1;
            ST_ON_HELD: begin
                armed   = 1'b1;
                pending = 1'b1;
                irq_req = inh_ok;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
    import irq_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] OFS_DISARM  = 4'hD,
    parameter logic [ADDR_W-1:0] OFS_ARM     = 4'hE,
    parameter logic [ADDR_W-1:0] OFS_CLEAR   = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              dio_in,
    input  logic              ext_in,
    input  logic              tick_in,
    input  logic              inhibit_n,
    input  logic              strap_src_sel,
    input  logic              strap_grp_en,
    input  logic              strap_tick_en,
    output logic              irq_out
);

    logic [SYNC_W-1:0] raw_in, syn_in;
    logic [SRC_N-1:0]  src_rise;
    logic              inh_ok;
    logic              grp_rise, tick_rise, edge_hit;
    logic              cmd_arm, cmd_disarm, cmd_clear;
    logic              armed, pending;

    always_comb begin
        raw_in           = '0;
        raw_in[SRC_DIO]  = dio_in;
        raw_in[SRC_EXT]  = ext_in;
        raw_in[SRC_TICK] = tick_in;
        raw_in[SRC_N]    = inhibit_n;
    end

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    // Edges are found on each line before selection, so moving the strap cannot fake one
    irq_rise_det #(.W(SRC_N)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (syn_in[SRC_N-1:0]),
        .rise  (src_rise)
    );

    assign inh_ok    = syn_in[SRC_N];
    assign grp_rise  = strap_grp_en & (strap_src_sel ? src_rise[SRC_EXT] : src_rise[SRC_DIO]);
    assign tick_rise = strap_tick_en & src_rise[SRC_TICK];
    assign edge_hit  = grp_rise | tick_rise;

    assign cmd_arm    = bus_wr && (bus_addr == OFS_ARM);
    assign cmd_disarm = bus_wr && (bus_addr == OFS_DISARM);
    assign cmd_clear  = bus_wr && (bus_addr == OFS_CLEAR);

    irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_arm    (cmd_arm),
        .cmd_disarm (cmd_disarm),
        .cmd_clear  (cmd_clear),
        .edge_hit   (edge_hit),
        .inh_ok     (inh_ok),
        .armed      (armed),
        .pending    (pending),
        .irq_req    (irq_out)
    );

endmodule

// File: rtl/irq_edge_chk.sv
module irq_edge_chk #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] OFS_DISARM = 4'hD,
    parameter logic [ADDR_W-1:0] OFS_ARM    = 4'hE,
    parameter logic [ADDR_W-1:0] OFS_CLEAR  = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_out,
    input logic              armed,
    input logic              pending,
    input logic              inh_ok,
    input logic              edge_hit
);

    logic other_wr;
    assign other_wr = bus_wr && (bus_addr != OFS_DISARM) && (bus_addr != OFS_ARM)
                      && (bus_addr != OFS_CLEAR);

    // R2
    a_r2_arm_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ARM) |=> armed);

    // R7
    a_r7_disarm_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DISARM) |=> (!armed && !irq_out));

    // R7
    a_r7_no_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !pending) |=> !pending);

    // R8
    a_r8_clear_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLEAR && !(edge_hit && armed && inh_ok)) |=> !pending);

    // R8
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && armed && inh_ok) |=> pending);

    // R9
    a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_ok |-> !irq_out);

    // R10
    a_r10_req_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pending && armed));

    // R11
    a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wr && !edge_hit) |=> ($stable(armed) && $stable(pending)));

endmodule

bind irq_edge_ctrl irq_edge_chk #(
    .ADDR_W     (ADDR_W),
    .OFS_DISARM (OFS_DISARM),
    .OFS_ARM    (OFS_ARM),
    .OFS_CLEAR  (OFS_CLEAR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq_out  (irq_out),
    .armed    (armed),
    .pending  (pending),
    .inh_ok   (inh_ok),
    .edge_hit (edge_hit)
);

// File: tb/tb_irq_edge_ctrl.sv
`timescale 1ns/1ps
module tb_irq_edge_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       dio_in = 1'b0;
    logic       ext_in = 1'b0;
    logic       tick_in = 1'b0;
    logic       inhibit_n = 1'b1;
    logic       strap_src_sel = 1'b0;
    logic       strap_grp_en = 1'b1;
    logic       strap_tick_en = 1'b1;
    logic       irq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_edge_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .dio_in        (dio_in),
        .ext_in        (ext_in),
        .tick_in       (tick_in),
        .inhibit_n     (inhibit_n),
        .strap_src_sel (strap_src_sel),
        .strap_grp_en  (strap_grp_en),
        .strap_tick_en (strap_tick_en),
        .irq_out       (irq_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [3:0] a);
        @(negedge clk);
        bus_wr   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_wr   = 1'b0;
    endtask

    task automatic set_src(input int which, input logic v);
        case (which)
            0: dio_in  = v;
            1: ext_in  = v;
            default: tick_in = v;
        endcase
    endtask

    // Full high then low pulse, long enough to pass the synchronizer and state register
    task automatic pulse(input int which);
        @(negedge clk);
        set_src(which, 1'b1);
        wait_n(4);
        set_src(which, 1'b0);
        wait_n(4);
    endtask

    task automatic t_reset;
        check("R1 request low after reset", irq_out, 1'b0);
        pulse(0);                         // edge while disarmed
        cmd(4'hE);
        wait_n(1);
        check("R1 latch empty and disarmed at reset", irq_out, 1'b0);
    endtask

    task automatic t_dio_latency;
        strap_src_sel = 1'b0;
        strap_grp_en  = 1'b1;
        @(negedge clk);
        dio_in = 1'b1;
        wait_n(2);
        check("R12 request still low after two edges", irq_out, 1'b0);
        wait_n(1);
        check("R12 request high on third edge", irq_out, 1'b1);
        check("R2 armed by address-only write", irq_out, 1'b1);
        wait_n(2);
        dio_in = 1'b0;
        wait_n(4);
        check("R3 latch sticky after falling edge", irq_out, 1'b1);
        cmd(4'hF);
        wait_n(1);
        check("R8 clear drops request", irq_out, 1'b0);
        @(negedge clk);
        dio_in = 1'b1;
        wait_n(4);
        cmd(4'hF);
        @(negedge clk);
        dio_in = 1'b0;
        wait_n(4);
        check("R3 falling edge sets nothing", irq_out, 1'b0);
    endtask

    task automatic t_ext_select;
        strap_src_sel = 1'b1;
        wait_n(1);
        pulse(0);
        check("R4 digital line ignored with external selected", irq_out, 1'b0);
        pulse(1);
        check("R4 external pin raises request", irq_out, 1'b1);
        cmd(4'hF);
        wait_n(1);
    endtask

    task automatic t_straps;
        strap_grp_en = 1'b0;
        wait_n(1);
        pulse(1);
        pulse(0);
        check("R5 group strap off blocks both group sources", irq_out, 1'b0);
        strap_tick_en = 1'b0;
        wait_n(1);
        pulse(2);
        check("R6 tick blocked by its strap", irq_out, 1'b0);
        strap_tick_en = 1'b1;
        wait_n(1);
        pulse(2);
        check("R6 tick raises request", irq_out, 1'b1);
        cmd(4'hF);
        wait_n(1);
        strap_grp_en  = 1'b1;
        strap_src_sel = 1'b0;
        wait_n(1);
    endtask

    task automatic t_disarm;
        pulse(0);
        check("R7 pending before disarm", irq_out, 1'b1);
        cmd(4'hD);
        wait_n(1);
        check("R7 disarm drops request", irq_out, 1'b0);
        cmd(4'hE);
        wait_n(1);
        check("R10 re-arm shows retained latch", irq_out, 1'b1);
        cmd(4'hD);
        cmd(4'hF);
        pulse(0);
        pulse(2);
        cmd(4'hE);
        wait_n(1);
        check("R7 edges while disarmed not captured", irq_out, 1'b0);
    endtask

    task automatic t_inhibit;
        pulse(2);
        inhibit_n = 1'b0;
        wait_n(3);
        check("R9 inhibit forces request low", irq_out, 1'b0);
        inhibit_n = 1'b1;
        wait_n(3);
        check("R9 pending shows after inhibit release", irq_out, 1'b1);
        cmd(4'hF);
        inhibit_n = 1'b0;
        wait_n(3);
        pulse(0);
        inhibit_n = 1'b1;
        wait_n(3);
        check("R9 edges under inhibit not captured", irq_out, 1'b0);
    endtask

    task automatic t_other_addr;
        for (int a = 0; a < 13; a++) cmd(4'(a));
        wait_n(1);
        check("R11 other offsets leave latch empty", irq_out, 1'b0);
        pulse(0);
        check("R11 still armed after other offsets", irq_out, 1'b1);
        for (int a = 0; a < 13; a++) cmd(4'(a));
        wait_n(1);
        check("R11 other offsets keep latch set", irq_out, 1'b1);
    endtask

    task automatic t_clear_race;
        // latch is set from the previous scenario; the line is low again
        @(negedge clk);
        dio_in = 1'b1;
        wait_n(2);                 // detected edge present before the next rising edge
        bus_wr   = 1'b1;
        bus_addr = 4'hF;
        @(negedge clk);
        bus_wr   = 1'b0;
        wait_n(1);
        check("R8 edge wins over same-cycle clear", irq_out, 1'b1);
        cmd(4'hF);
        wait_n(1);
        check("R8 lone clear afterwards", irq_out, 1'b0);
        dio_in = 1'b0;
        wait_n(4);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_dio_latency();
        t_ext_select();
        t_straps();
        t_disarm();
        t_inhibit();
        t_other_addr();
        t_clear_race();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule